// File: doc/BRIEF.md
# Per-Slice Lookup Event Counter Bank

This block holds one small performance monitoring unit for each slice of a sliced shared cache. Each unit pairs a control register with a 48-bit event counter. It counts the lookups that arrive at its own slice, so software that issues a chosen access can read every slice's counter and see which slice received it. Each lookup arrives as a strobe with a two-bit request type. The control register of a unit enables it, selects the lookup event and masks which request types are counted.

Access goes through one privileged register port that reads and writes words. A register address is made of a slice index and a one-bit selector for control or counter. Counters include traffic from every requester, with no split by process. A global freeze input stops all counting at once, so a snapshot can be read while the registers stay writable. Counters saturate instead of wrapping.

Top module: `slice_lookup_pmu_bank`

## Requirements
- R1: Each slice has its own control register and its own counter. A lookup strobe on slice s can change only counter s.
- R2: Register address bit 0 selects control (0) or counter (1), and the upper address bits give the slice index. The control word is laid out as: enable in bit 0, clear in bit 1, event select in bits 9..2, and request-type mask in bits 13..10. Reads return that word zero-extended, or the counter value.
- R3: A lookup is counted, adding one per cycle, when all of these hold: enable=1, event select=8'h34, and the mask bit 10+type is set. The type codes are 0 read, 1 write, 2 snoop, 3 flush.
- R4: A flush lookup (type 3) is counted like any other request type. No line-presence input affects counting, and a mask of 4'hF counts every type.
- R5: A lookup is not counted while its unit is disabled, while the event select is other than 8'h34, or while its type's mask bit is clear.
- R6: While freeze is high, no lookup is counted. Register writes and clears still take effect.
- R7: Writing a control word with bit 1 set makes the counter 0 after the edge, even when a counted lookup arrives in the same cycle. Bit 1 is never stored and always reads 0.
- R8: A write to the counter address loads the counter with the write data. This write wins over a lookup in the same cycle.
- R9: A counter at 2^48-1 stays there when further lookups are counted.
- R10: reg_rdata is combinational. While reg_rd is high it shows the addressed register as it was before the coming clock edge. While reg_rd is low it is 0.
- R11: After a synchronous reset, every control register and every counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | NUM_SLICES | Lookup strobe, one bit per slice |
| lk_type | input | 2*NUM_SLICES | Request type per slice, two bits each, slice s at bits 2s+1..2s |
| freeze | input | 1 | Halts counting in all units |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | SLICE_W+1 | {slice index, control/counter select} |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data |

## Verification
The assertions take for granted that reg_wr and reg_rd are never high together on one address. They also take for granted that lookup types are always valid two-bit codes, so a saturated or stable counter can change only through a clear or a counter write. The stimulus raises only one of the two port strobes in any cycle. It drives lookups with types drawn from the four codes. It places clears and counter loads in the same cycles as counted lookups, so that the precedence between them is what gets checked.

// File: rtl/slpmu_pkg.sv
package slpmu_pkg;

    localparam int CTRL_W = 14;
    localparam logic [7:0] EV_LOOKUP = 8'h34;

    typedef enum logic [1:0] {
        REQ_READ  = 2'd0,
        REQ_WRITE = 2'd1,
        REQ_SNOOP = 2'd2,
        REQ_FLUSH = 2'd3
    } req_type_e;

    typedef struct packed {
        logic [3:0] mask;   // bits 13..10
        logic [7:0] evsel;  // bits 9..2
        logic       clr;    // bit 1, never held
        logic       en;     // bit 0
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c = ctrl_t'(w);
        c.clr = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/slpmu_match.sv
module slpmu_match
    import slpmu_pkg::*;
(
    input  logic       en,
    input  logic [7:0] evsel,
    input  logic [3:0] mask,
    input  logic       freeze,
    input  logic       lk_valid,
    input  req_type_e  lk_type,
    output logic       hit
);
    logic type_ok;

    always_comb begin
        type_ok = mask[lk_type];
        hit = lk_valid && en && !freeze && (evsel == EV_LOOKUP) && type_ok;
    end

endmodule

// File: rtl/slpmu_unit.sv
module slpmu_unit
    import slpmu_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    input  logic             lk_valid,
    input  req_type_e        lk_type,
    input  logic             ctrl_we,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic hit;
    logic clr_req;

    assign clr_req = ctrl_we && wdata[1];

    slpmu_match match_i (
        .en       (ctrl_q.en),
        .evsel    (ctrl_q.evsel),
        .mask     (ctrl_q.mask),
        .freeze   (freeze),
        .lk_valid (lk_valid),
        .lk_type  (lk_type),
        .hit      (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl_q <= ctrl_from_word(wdata[CTRL_W-1:0]);
            end
            if (clr_req) begin
                cnt_q <= '0;
            end else if (cnt_we) begin
                cnt_q <= wdata;
            end else if (hit && (cnt_q != CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> (cnt_q == '0)); // R7

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        ((cnt_q == CNT_MAX) && !ctrl_we && !cnt_we) |=> (cnt_q == CNT_MAX)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!hit && !ctrl_we && !cnt_we) |=> $stable(cnt_q)); // R5

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_we && !cnt_we) |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1))); // R3

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (cnt_we && !clr_req) |=> (cnt_q == $past(wdata))); // R8

    AST_CLR_NOT_HELD: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> (ctrl_q.clr == 1'b0)); // R7

endmodule

// File: rtl/slice_lookup_pmu_bank.sv
module slice_lookup_pmu_bank
    import slpmu_pkg::*;
#(
    parameter int NUM_SLICES = 4,
    parameter int CNT_W      = 48,
    parameter int SLICE_W    = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_SLICES-1:0]   lk_valid,
    input  logic [2*NUM_SLICES-1:0] lk_type,
    input  logic                    freeze,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [SLICE_W:0]        reg_addr,
    input  logic [CNT_W-1:0]        reg_wdata,
    output logic [CNT_W-1:0]        reg_rdata
);
    logic [SLICE_W-1:0] sel_slice;
    logic               sel_cnt;
    logic [CNT_W-1:0]   rd_word [NUM_SLICES];
    logic [NUM_SLICES-1:0] ctrl_we_v;
    logic [NUM_SLICES-1:0] cnt_we_v;

    assign sel_slice = reg_addr[SLICE_W:1];
    assign sel_cnt   = reg_addr[0];

    for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
        ctrl_t              ctrl_q;
        logic [CTRL_W-1:0]  ctrl_bits;
        logic [CNT_W-1:0]   cnt_q;
        logic               addr_hit;

        assign addr_hit     = reg_wr && (sel_slice == SLICE_W'(g));
        assign ctrl_we_v[g] = addr_hit && !sel_cnt;
        assign cnt_we_v[g]  = addr_hit && sel_cnt;

        slpmu_unit #(.CNT_W(CNT_W)) unit_i (
            .clk      (clk),
            .rst      (rst),
            .freeze   (freeze),
            .lk_valid (lk_valid[g]),
            .lk_type  (req_type_e'(lk_type[2*g +: 2])),
            .ctrl_we  (ctrl_we_v[g]),
            .cnt_we   (cnt_we_v[g]),
            .wdata    (reg_wdata),
            .ctrl_q   (ctrl_q),
            .cnt_q    (cnt_q)
        );

        assign ctrl_bits  = ctrl_q;
        assign rd_word[g] = sel_cnt ? cnt_q : CNT_W'(ctrl_bits);
    end

    always_comb begin
        reg_rdata = '0;
        for (int s = 0; s < NUM_SLICES; s++) begin
            if (reg_rd && (sel_slice == SLICE_W'(s))) begin
                reg_rdata = rd_word[s];
            end
        end
    end

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |-> (reg_rdata == '0)); // R10

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl_we_v, cnt_we_v})); // R1

endmodule

// File: tb/slice_lookup_pmu_bank_tb_top.sv
module slice_lookup_pmu_bank_tb_top;
    localparam int NS    = 4;
    localparam int CW    = 48;
    localparam int SW    = 2;
    localparam logic [CW-1:0] MAXV = '1;

    logic          clk = 1'b0;
    logic          rst;
    logic [NS-1:0] lk_valid;
    logic [2*NS-1:0] lk_type;
    logic          freeze;
    logic          reg_wr, reg_rd;
    logic [SW:0]   reg_addr;
    logic [CW-1:0] reg_wdata;
    logic [CW-1:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [13:0]   ctrl_m [NS];
    logic [CW-1:0] cnt_m  [NS];

    always #2 clk = ~clk;

    slice_lookup_pmu_bank #(.NUM_SLICES(NS), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_type(lk_type),
        .freeze(freeze), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [CW-1:0] model_read(input logic [SW:0] a);
        if (a[0]) return cnt_m[a[SW:1]];
        return CW'(ctrl_m[a[SW:1]]);
    endfunction

    task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: inputs applied after a falling edge, output checked, model stepped at the rising edge.
    task automatic step(input logic [NS-1:0] v, input logic [2*NS-1:0] t, input logic frz,
                        input logic wr, input logic rd, input logic [SW:0] a,
                        input logic [CW-1:0] wd, input string tag);
        lk_valid = v; lk_type = t; freeze = frz;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        #1;
        if (rd) check(tag, reg_rdata, model_read(a));
        else    check("R10 idle", reg_rdata, '0);
        @(posedge clk);
        for (int s = 0; s < NS; s++) begin
            logic [1:0] ty;
            logic hit, clr, we_c, we_n;
            ty   = t[2*s +: 2];
            hit  = v[s] && ctrl_m[s][0] && (ctrl_m[s][9:2] == 8'h34) && ctrl_m[s][10+ty] && !frz;
            we_c = wr && (a[SW:1] == SW'(s)) && !a[0];
            we_n = wr && (a[SW:1] == SW'(s)) && a[0];
            clr  = we_c && wd[1];
            if (we_c) ctrl_m[s] = wd[13:0] & ~14'd2;
            if (clr)        cnt_m[s] = '0;
            else if (we_n)  cnt_m[s] = wd;
            else if (hit && cnt_m[s] != MAXV) cnt_m[s] = cnt_m[s] + 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, 1'b0, 1'b0, 1'b0, '0, '0, "R10");
    endtask

    task automatic wr_ctrl(input int s, input logic [3:0] mask, input logic [7:0] ev,
                           input logic clr, input logic en, input logic [NS-1:0] v, input logic [2*NS-1:0] t);
        step(v, t, 1'b0, 1'b1, 1'b0, {SW'(s), 1'b0}, CW'({mask, ev, clr, en}), "R2");
    endtask

    task automatic rd_reg(input int s, input logic sel, input string tag);
        step('0, '0, 1'b0, 1'b0, 1'b1, {SW'(s), sel}, '0, tag);
    endtask

    task automatic read_all(input string tag);
        for (int s = 0; s < NS; s++) begin
            rd_reg(s, 1'b0, tag);
            rd_reg(s, 1'b1, tag);
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) begin ctrl_m[s] = '0; cnt_m[s] = '0; end
        rst = 1'b1; lk_valid = '0; lk_type = '0; freeze = 1'b0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        read_all("R11 reset");

        // R3 R4: slice0 reads, slice1 writes, slice2 snoop+flush, slice3 all types
        wr_ctrl(0, 4'b0001, 8'h34, 1'b0, 1'b1, '0, '0);
        wr_ctrl(1, 4'b0010, 8'h34, 1'b0, 1'b1, '0, '0);
        wr_ctrl(2, 4'b1100, 8'h34, 1'b0, 1'b1, '0, '0);
        wr_ctrl(3, 4'b1111, 8'h34, 1'b0, 1'b1, '0, '0);
        read_all("R2 ctrl readback");
        for (int ty = 0; ty < 4; ty++)
            for (int k = 0; k < 3; k++)
                step(4'b1111, {4{2'(ty)}}, 1'b0, 1'b0, 1'b0, '0, '0, "R3");
        read_all("R3 R4 type filter");

        // R1: strobe only slice 2 with flush
        for (int k = 0; k < 5; k++) step(4'b0100, 8'hFF, 1'b0, 1'b0, 1'b0, '0, '0, "R1");
        read_all("R1 R4 isolation");

        // random traffic with interleaved reads
        for (int i = 0; i < 400; i++) begin
            logic [NS-1:0] v; logic [2*NS-1:0] t; logic rd; logic [SW:0] a;
            v = NS'($urandom); t = (2*NS)'($urandom); rd = ($urandom % 3) == 0; a = (SW+1)'($urandom);
            step(v, t, 1'b0, 1'b0, rd, a, '0, "R3 random");
        end
        read_all("R3 random end");

        // R5: disable slice1, wrong event on slice2, mask cleared on slice0
        wr_ctrl(1, 4'b1111, 8'h34, 1'b0, 1'b0, '0, '0);
        wr_ctrl(2, 4'b1111, 8'h35, 1'b0, 1'b1, '0, '0);
        wr_ctrl(0, 4'b1110, 8'h34, 1'b0, 1'b1, '0, '0);
        for (int k = 0; k < 6; k++) step(4'b1111, 8'h00, 1'b0, 1'b0, 1'b0, '0, '0, "R5");
        read_all("R5 no count");

        // R6: freeze stops counting, write still lands
        for (int k = 0; k < 6; k++) step(4'b1111, 8'hFF, 1'b1, 1'b0, 1'b0, '0, '0, "R6");
        step('0, '0, 1'b1, 1'b1, 1'b0, {2'd3, 1'b1}, CW'(48'd77), "R6");
        read_all("R6 freeze");

        // R7: clear with a counted lookup in the same cycle
        wr_ctrl(3, 4'b1111, 8'h34, 1'b1, 1'b1, 4'b1000, 8'hC0);
        rd_reg(3, 1'b1, "R7 clear wins");
        rd_reg(3, 1'b0, "R7 clear bit reads 0");

        // R8: counter load with a counted lookup in the same cycle
        step(4'b1000, 8'h00, 1'b0, 1'b1, 1'b0, {2'd3, 1'b1}, CW'(48'h1234), "R8");
        rd_reg(3, 1'b1, "R8 load wins");

        // R9: saturation
        step('0, '0, 1'b0, 1'b1, 1'b0, {2'd3, 1'b1}, MAXV - 2, "R9");
        for (int k = 0; k < 5; k++) step(4'b1000, 8'h40, 1'b0, 1'b0, 1'b0, '0, '0, "R9");
        rd_reg(3, 1'b1, "R9 saturate");
        check("R9 value", cnt_m[3], MAXV);

        // R10: read in the same cycle as a counted lookup sees the old value
        step(4'b1000, 8'h00, 1'b0, 1'b0, 1'b1, {2'd3, 1'b1}, '0, "R10 pre-edge");
        step('0, '0, 1'b0, 1'b1, 1'b0, {2'd3, 1'b1}, CW'(48'd9), "R10");
        step(4'b1000, 8'h00, 1'b0, 1'b0, 1'b1, {2'd3, 1'b1}, '0, "R10 pre-edge");
        rd_reg(3, 1'b1, "R10 post-edge");
        check("R10 value", cnt_m[3], CW'(48'd10));

        idle(2);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule